// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Aggregator

This block is the register-side companion of a multi-channel DMA engine. For each channel it holds one control/status word. That word carries a run enable, a descriptor-less mode select, a stop-interrupt enable, three sticky event flags and two live status bits. The channel engines feed it one-cycle event pulses: transfer started, transfer ended, bus error, and transfer boundary reached. It hands back per-channel run and mode enables.

A summary word has one bit per channel. The bit is set while that channel wants service, and the OR of the summary bits forms the single interrupt line. Software reads the summary word to find which channels need attention. It then reads each flagged channel word and writes the same value back, which clears exactly the flags it saw.

The block also holds a routing table for peripheral request lines. Each entry either connects its request line to one channel or leaves the line unconnected. A per-channel alignment-relaxation register completes the set. All registers are reached through a plain word-addressed read/write port. Reads are combinational and writes take effect at the clock edge.

Top module: `dma_stat_irq_hub`

## Requirements
- R1: After reset every channel word reads 0x0000_0008 (only the stopped flag at bit 3 set), the summary, alignment and routing entries read zero, `irq` is low, and `run_en`, `nodesc_en`, `unaligned_ok` and `chan_req` are all zero.
- R2: The channel word for channel n sits at byte offset 4n. Bit 31 (run), bit 30 (descriptor-less mode) and bit 29 (stop-interrupt enable) are written directly and read back. Bit 31 drives `run_en[n]` and bit 30 drives `nodesc_en[n]` from the edge after the write.
- R3: A pulse on `ev_end[n]`, `ev_start[n]` or `ev_buserr[n]` sets bit 2, bit 1 or bit 0 of channel word n at the next edge. The flag then stays set until software clears it.
- R4: Writing 1 to any of bits 2..0 clears that flag, and writing 0 leaves it unchanged, so writing back a value just read clears every flag that was set. If an event pulse arrives in the same cycle as the clear, the flag stays set.
- R5: Bit 3 (stopped) is set at the first `ev_boundary[n]` pulse seen while run is 0. A write with bit 31 = 1 clears it at that edge. A boundary pulse while run is 1 leaves it unchanged.
- R6: The summary word at offset 0x084 has bit n set while channel n has any of bits 2..0 set, or has both bit 29 and bit 3 set. Bits at or above the channel count read 0, writes to the summary word are ignored, and `irq` is the OR of all summary bits.
- R7: A routing entry reads as bit 7 = valid and bits 4:0 = channel number, with all other bits 0. Writing zero to an entry unmaps its request line.
- R8: Request r below 64 has its entry at offset 0x100 + 4r. Request r from 64 up has its entry at 0x200 + 4(r-64). Entries at or beyond the request count read 0, and writes to them are ignored.
- R9: `chan_req[c]` is high while at least one asserted `req_in[r]` has a valid entry whose channel number equals c. The same level appears as bit 8 of channel word c. An invalid entry, or a channel number at or above the channel count, routes the request nowhere.
- R10: The alignment word at offset 0x080 holds one bit per channel. Bit n drives `unaligned_ok[n]`, and bits at or above the channel count read 0.
- R11: A read of any address not listed above, or of an address that is not a multiple of 4, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 10 | Byte address of register access |
| reg_wr | input | 1 | Write strobe, applied at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| ev_start | input | NCH | Per-channel transfer-start pulse |
| ev_end | input | NCH | Per-channel transfer-end pulse |
| ev_buserr | input | NCH | Per-channel bus-error pulse |
| ev_boundary | input | NCH | Per-channel transfer-boundary pulse |
| req_in | input | NREQ | Peripheral request lines |
| run_en | output | NCH | Per-channel run enable |
| nodesc_en | output | NCH | Per-channel descriptor-less mode enable |
| unaligned_ok | output | NCH | Per-channel unaligned-address permission |
| chan_req | output | NCH | Routed request level per channel |
| irq | output | 1 | Combined interrupt |

## Verification
A flag that is wrongly held or wrongly dropped appears in two places one edge after the pulse or write: the channel word read-back and the `irq` level. A broken set-versus-clear ordering therefore shows at the very next read. A wrong stop sequence shows as bit 3 rising on the wrong boundary pulse. A routing-table entry that was corrupted or decoded into the wrong bank shows combinationally on `chan_req`, and on bit 8 of the target channel word, as soon as the matching request line is raised. The bench drives each of these corners directly. It then runs a long random mix of writes, write-backs and events, and checks every output and a read-back after each edge.

// File: rtl/dma_hub_pkg.sv
package dma_hub_pkg;

  localparam int ADDR_W    = 10;
  localparam int MAP_IW    = 7;
  localparam int ALIGN_OFF = 'h080;
  localparam int SUM_OFF   = 'h084;
  localparam int BANK_LO   = 'h100;
  localparam int BANK_HI   = 'h200;

  localparam int B_RUN  = 31;
  localparam int B_NDSC = 30;
  localparam int B_SIE  = 29;
  localparam int B_END  = 2;
  localparam int B_STRT = 1;
  localparam int B_BERR = 0;
  localparam int B_MVAL = 7;

  typedef struct packed {
    logic       valid;
    logic [4:0] chan;
  } route_ent_t;

  typedef struct packed {
    logic              hit;
    logic [MAP_IW-1:0] idx;
  } route_sel_t;

  function automatic logic [31:0] pack_chan_word(
      logic run, logic nd, logic sie, logic reqp,
      logic stp, logic endf, logic stf, logic bef);
    return {run, nd, sie, 20'b0, reqp, 4'b0, stp, endf, stf, bef};
  endfunction

  function automatic logic [31:0] pack_route_word(route_ent_t e);
    return {24'b0, e.valid, 2'b0, e.chan};
  endfunction

  function automatic route_sel_t decode_route(logic [ADDR_W-1:0] a, int nreq);
    route_sel_t s;
    s.idx = {a[9], a[7:2]};
    s.hit = (a[9:8] == 2'b01 || a[9:8] == 2'b10) && (a[1:0] == 2'b00)
            && (int'(s.idx) < nreq);
    return s;
  endfunction

endpackage

// File: rtl/dma_chan_csr.sv
module dma_chan_csr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sel,
  input  logic [2:0] wr_ctl,
  input  logic [2:0] wr_clr,
  input  logic       ev_start,
  input  logic       ev_end,
  input  logic       ev_berr,
  input  logic       ev_bnd,
  input  logic       req_pend,
  output logic [31:0] rd_word,
  output logic       run_o,
  output logic       nodesc_o,
  output logic       irq_src_o,
  output logic       flag_any_o
);
  import dma_hub_pkg::*;

  logic run_q, nd_q, sie_q, stp_q, end_q, st_q, be_q;
  logic run_set, stop_hit;

  assign run_set  = wr_sel & wr_ctl[2];
  assign stop_hit = ~run_q & ev_bnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      nd_q  <= 1'b0;
      sie_q <= 1'b0;
      stp_q <= 1'b1;
      end_q <= 1'b0;
      st_q  <= 1'b0;
      be_q  <= 1'b0;
    end else begin
      if (wr_sel) begin
        run_q <= wr_ctl[2];
        nd_q  <= wr_ctl[1];
        sie_q <= wr_ctl[0];
      end
      if (run_set)       stp_q <= 1'b0;
      else if (stop_hit) stp_q <= 1'b1;
      end_q <= ev_end   | (end_q & ~(wr_sel & wr_clr[2]));
      st_q  <= ev_start | (st_q  & ~(wr_sel & wr_clr[1]));
      be_q  <= ev_berr  | (be_q  & ~(wr_sel & wr_clr[0]));
    end
  end

  assign rd_word    = pack_chan_word(run_q, nd_q, sie_q, req_pend, stp_q, end_q, st_q, be_q);
  assign run_o      = run_q;
  assign nodesc_o   = nd_q;
  assign flag_any_o = end_q | st_q | be_q;
  assign irq_src_o  = flag_any_o | (sie_q & stp_q);

  assert_run_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (run_o == $past(wr_ctl[2])));
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && !(wr_sel && wr_clr[2])) |=> end_q);
  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && wr_clr[0] && !ev_berr) |=> !be_q);
  assert_stop_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && ev_bnd && !(wr_sel && wr_ctl[2])) |=> stp_q);

endmodule

// File: rtl/dma_req_router.sv
module dma_req_router #(
  parameter int NCH  = 8,
  parameter int NREQ = 72
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [dma_hub_pkg::MAP_IW-1:0] wr_idx,
  input  logic [7:0]                    wdata,
  input  logic [dma_hub_pkg::MAP_IW-1:0] rd_idx,
  input  logic [NREQ-1:0]               req_in,
  output logic [31:0]                   rd_word,
  output logic [NCH-1:0]                chan_req
);
  import dma_hub_pkg::*;

  localparam int SLOTS = 1 << MAP_IW;

  route_ent_t tbl [NREQ];
  logic [SLOTS-1:0][31:0] word_all;

  for (genvar r = 0; r < SLOTS; r++) begin : g_slot
    if (r < NREQ) begin : g_real
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl[r] <= '0;
        else if (wr_en && wr_idx == MAP_IW'(r))
          tbl[r] <= '{valid: wdata[B_MVAL], chan: wdata[4:0]};
      end
      assign word_all[r] = pack_route_word(tbl[r]);
    end else begin : g_pad
      assign word_all[r] = '0;
    end
  end

  assign rd_word = word_all[rd_idx];

  always_comb begin
    chan_req = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < NREQ; r++) begin
        if (req_in[r] && tbl[r].valid && tbl[r].chan == 5'(c)) chan_req[c] = 1'b1;
      end
    end
  end

  assert_route_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_req) |-> (|req_in));

endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] src,
  output logic [31:0]    sum_word,
  output logic           irq
);
  assign sum_word = 32'(src);
  assign irq      = |src;
endmodule

// File: rtl/dma_stat_irq_hub.sv
module dma_stat_irq_hub #(
  parameter int NCH  = 8,
  parameter int NREQ = 72
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [dma_hub_pkg::ADDR_W-1:0] reg_addr,
  input  logic                          reg_wr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic [NCH-1:0]                ev_start,
  input  logic [NCH-1:0]                ev_end,
  input  logic [NCH-1:0]                ev_buserr,
  input  logic [NCH-1:0]                ev_boundary,
  input  logic [NREQ-1:0]               req_in,
  output logic [NCH-1:0]                run_en,
  output logic [NCH-1:0]                nodesc_en,
  output logic [NCH-1:0]                unaligned_ok,
  output logic [NCH-1:0]                chan_req,
  output logic                          irq
);
  import dma_hub_pkg::*;

  localparam int CH_SLOTS = 32;

  logic                      ctl_hit, align_hit, sum_hit;
  logic [4:0]                ctl_idx;
  route_sel_t                rsel;
  logic [CH_SLOTS-1:0][31:0] csr_all;
  logic [NCH-1:0]            irq_src, flag_any;
  logic [NCH-1:0]            align_q;
  logic [31:0]               sum_word, route_word;

  assign ctl_idx   = reg_addr[6:2];
  assign ctl_hit   = (reg_addr[9:7] == 3'b000) && (reg_addr[1:0] == 2'b00)
                     && (int'(ctl_idx) < NCH);
  assign align_hit = (int'(reg_addr) == ALIGN_OFF);
  assign sum_hit   = (int'(reg_addr) == SUM_OFF);
  assign rsel      = decode_route(reg_addr, NREQ);

  for (genvar n = 0; n < CH_SLOTS; n++) begin : g_ch
    if (n < NCH) begin : g_live
      dma_chan_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (reg_wr && ctl_hit && ctl_idx == 5'(n)),
        .wr_ctl     (reg_wdata[B_RUN:B_SIE]),
        .wr_clr     (reg_wdata[B_END:B_BERR]),
        .ev_start   (ev_start[n]),
        .ev_end     (ev_end[n]),
        .ev_berr    (ev_buserr[n]),
        .ev_bnd     (ev_boundary[n]),
        .req_pend   (chan_req[n]),
        .rd_word    (csr_all[n]),
        .run_o      (run_en[n]),
        .nodesc_o   (nodesc_en[n]),
        .irq_src_o  (irq_src[n]),
        .flag_any_o (flag_any[n])
      );
    end else begin : g_none
      assign csr_all[n] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) align_q <= '0;
    else if (reg_wr && align_hit) align_q <= reg_wdata[NCH-1:0];
  end
  assign unaligned_ok = align_q;

  dma_req_router #(.NCH(NCH), .NREQ(NREQ)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr && rsel.hit),
    .wr_idx   (rsel.idx),
    .wdata    (reg_wdata[7:0]),
    .rd_idx   (rsel.idx),
    .req_in   (req_in),
    .rd_word  (route_word),
    .chan_req (chan_req)
  );

  dma_irq_merge #(.NCH(NCH)) u_merge (
    .src      (irq_src),
    .sum_word (sum_word),
    .irq      (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (ctl_hit)        reg_rdata = csr_all[ctl_idx];
    else if (align_hit) reg_rdata = 32'(align_q);
    else if (sum_hit)   reg_rdata = sum_word;
    else if (rsel.hit)  reg_rdata = route_word;
  end

  assert_flag_drives_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_any) |-> irq);
  assert_align_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && align_hit) |=> (unaligned_ok == $past(reg_wdata[NCH-1:0])));

endmodule

// File: tb/sim_dma_stat_irq_hub.sv
`timescale 1ns/1ps
module sim_dma_stat_irq_hub;
  localparam int NCH  = 8;
  localparam int NREQ = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] ev_start = '0, ev_end = '0, ev_buserr = '0, ev_boundary = '0;
  logic [NREQ-1:0] req_in = '0;
  logic [NCH-1:0] run_en, nodesc_en, unaligned_ok, chan_req;
  logic irq;

  always #4 clk = ~clk;

  dma_stat_irq_hub #(.NCH(NCH), .NREQ(NREQ)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_start(ev_start),
    .ev_end(ev_end), .ev_buserr(ev_buserr), .ev_boundary(ev_boundary),
    .req_in(req_in), .run_en(run_en), .nodesc_en(nodesc_en),
    .unaligned_ok(unaligned_ok), .chan_req(chan_req), .irq(irq));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bit [NCH-1:0] m_run = '0, m_nd = '0, m_sie = '0, m_stp = '1;
  bit [NCH-1:0] m_end = '0, m_st = '0, m_be = '0, m_al = '0;
  bit           m_v [NREQ];
  bit [4:0]     m_c [NREQ];

  function automatic bit [NCH-1:0] f_creq();
    bit [NCH-1:0] v = '0;
    for (int r = 0; r < NREQ; r++)
      if (req_in[r] && m_v[r] && m_c[r] < NCH) v[m_c[r]] = 1'b1;
    return v;
  endfunction

  function automatic bit [NCH-1:0] f_sum();
    return m_end | m_st | m_be | (m_sie & m_stp);
  endfunction

  function automatic bit [31:0] f_chan(int n);
    bit [31:0] w = '0;
    bit [NCH-1:0] cr = f_creq();
    w[31] = m_run[n]; w[30] = m_nd[n]; w[29] = m_sie[n]; w[8] = cr[n];
    w[3] = m_stp[n]; w[2] = m_end[n]; w[1] = m_st[n]; w[0] = m_be[n];
    return w;
  endfunction

  function automatic int f_req_of(bit [9:0] a);
    if (a[1:0] != 0) return -1;
    if (a >= 10'h100 && a < 10'h200) return (a - 10'h100) / 4;
    if (a >= 10'h200 && a < 10'h300) return 64 + (a - 10'h200) / 4;
    return -1;
  endfunction

  function automatic bit [31:0] f_read(bit [9:0] a);
    int r;
    if (a[1:0] != 0) return 0;
    if (a < 10'h080) return (a / 4 < NCH) ? f_chan(a / 4) : 0;
    if (a == 10'h080) return {{(32-NCH){1'b0}}, m_al};
    if (a == 10'h084) return {{(32-NCH){1'b0}}, f_sum()};
    r = f_req_of(a);
    if (r >= 0 && r < NREQ) return {24'b0, m_v[r], 2'b0, m_c[r]};
    return 0;
  endfunction

  task automatic chk(string tag, bit [31:0] act, bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(string tag, bit [9:0] a);
    reg_addr = a; reg_wr = 1'b0; #1;
    chk(tag, reg_rdata, f_read(a));
  endtask

  task automatic chk_outs(string tag);
    chk({tag, " run_en R2"},       32'(run_en),       32'(m_run));
    chk({tag, " nodesc_en R2"},    32'(nodesc_en),    32'(m_nd));
    chk({tag, " unaligned_ok R10"},32'(unaligned_ok), 32'(m_al));
    chk({tag, " chan_req R9"},     32'(chan_req),     32'(f_creq()));
    chk({tag, " irq R6"},          32'(irq),          32'(|f_sum()));
  endtask

  task automatic step(bit w, bit [9:0] a, bit [31:0] d,
                      bit [NCH-1:0] es, bit [NCH-1:0] ee,
                      bit [NCH-1:0] eb, bit [NCH-1:0] bd);
    int r;
    reg_addr = a; reg_wr = w; reg_wdata = d;
    ev_start = es; ev_end = ee; ev_buserr = eb; ev_boundary = bd;
    @(posedge clk);
    for (int n = 0; n < NCH; n++) begin
      bit hitn = w && a[1:0] == 0 && a < 10'h080 && (a / 4) == n;
      if (hitn && d[31]) m_stp[n] = 1'b0;
      else if (!m_run[n] && bd[n]) m_stp[n] = 1'b1;
      m_end[n] = ee[n] | (m_end[n] & !(hitn && d[2]));
      m_st[n]  = es[n] | (m_st[n]  & !(hitn && d[1]));
      m_be[n]  = eb[n] | (m_be[n]  & !(hitn && d[0]));
      if (hitn) begin m_run[n] = d[31]; m_nd[n] = d[30]; m_sie[n] = d[29]; end
    end
    if (w && a == 10'h080) m_al = d[NCH-1:0];
    r = f_req_of(a);
    if (w && r >= 0 && r < NREQ) begin m_v[r] = d[7]; m_c[r] = d[4:0]; end
    @(negedge clk);
    reg_wr = 1'b0; ev_start = '0; ev_end = '0; ev_buserr = '0; ev_boundary = '0;
  endtask

  task automatic idle();
    step(0, 10'h3FC, 0, '0, '0, '0, '0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < NREQ; r++) begin m_v[r] = 0; m_c[r] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    reg_addr = 10'h000; #1; chk("R1 ch0 word", reg_rdata, 32'h0000_0008);
    reg_addr = 10'h01C; #1; chk("R1 ch7 word", reg_rdata, 32'h0000_0008);
    reg_addr = 10'h084; #1; chk("R1 summary", reg_rdata, 32'h0);
    reg_addr = 10'h080; #1; chk("R1 align", reg_rdata, 32'h0);
    reg_addr = 10'h21C; #1; chk("R1 route 71", reg_rdata, 32'h0);
    chk("R1 outputs", {run_en, nodesc_en, unaligned_ok, chan_req}, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R2 control bits
    step(1, 10'h008, 32'hE000_0000, '0, '0, '0, '0);
    reg_addr = 10'h008; #1; chk("R2 ch2 ctl readback", reg_rdata, 32'hE000_0000);
    chk_outs("R2 after ctl write");
    // R5 stop sequence
    step(1, 10'h008, 32'h6000_0000, '0, '0, '0, '0);
    reg_addr = 10'h008; #1; chk("R5 no stop before boundary", reg_rdata, 32'h6000_0000);
    step(0, 10'h3FC, 0, '0, '0, '0, 8'h04);
    reg_addr = 10'h008; #1; chk("R5 stopped at boundary", reg_rdata, 32'h6000_0008);
    chk("R6 stop irq", 32'(irq), 32'h1);
    reg_addr = 10'h084; #1; chk("R6 summary stop bit", reg_rdata, 32'h0000_0004);
    step(1, 10'h008, 32'h8000_0000, '0, '0, '0, '0);
    step(0, 10'h3FC, 0, '0, '0, '0, 8'h04);
    reg_addr = 10'h008; #1; chk("R5 boundary while running ignored", reg_rdata, 32'h8000_0000);
    chk("R6 irq low", 32'(irq), 32'h0);

    // R3 sticky event flags
    step(0, 10'h3FC, 0, '0, 8'h20, '0, '0);
    idle(); idle();
    reg_addr = 10'h014; #1; chk("R3 end flag sticky", reg_rdata, 32'h0000_000C);
    reg_addr = 10'h084; #1; chk("R6 summary end", reg_rdata, 32'h0000_0020);
    step(0, 10'h3FC, 0, 8'h20, '0, 8'h20, '0);
    reg_addr = 10'h014; #1; chk("R3 all flags", reg_rdata, 32'h0000_000F);
    // R4 write-back clear
    step(1, 10'h014, 32'h0000_000F, '0, '0, '0, '0);
    reg_addr = 10'h014; #1; chk("R4 write-back clears", reg_rdata, 32'h0000_0008);
    chk("R4 irq after clear", 32'(irq), 32'h0);
    step(1, 10'h014, 32'h0000_0002, 8'h20, '0, '0, '0);
    reg_addr = 10'h014; #1; chk("R4 set wins over clear", reg_rdata, 32'h0000_000A);
    step(1, 10'h014, 32'h0000_0000, '0, '0, '0, '0);
    reg_addr = 10'h014; #1; chk("R4 zero keeps flag", reg_rdata, 32'h0000_000A);
    step(1, 10'h014, 32'h0000_0002, '0, '0, '0, '0);
    reg_addr = 10'h014; #1; chk("R4 one clears flag", reg_rdata, 32'h0000_0008);

    // R7 R8 routing table and banks
    step(1, 10'h10C, 32'h0000_00FF, '0, '0, '0, '0);
    reg_addr = 10'h10C; #1; chk("R7 entry fields", reg_rdata, 32'h0000_009F);
    step(1, 10'h1FC, 32'h0000_0083, '0, '0, '0, '0);
    step(1, 10'h200, 32'h0000_0081, '0, '0, '0, '0);
    step(1, 10'h21C, 32'h0000_0086, '0, '0, '0, '0);
    step(1, 10'h220, 32'h0000_0082, '0, '0, '0, '0);
    reg_addr = 10'h1FC; #1; chk("R8 request 63 low bank", reg_rdata, 32'h0000_0083);
    reg_addr = 10'h200; #1; chk("R8 request 64 high bank", reg_rdata, 32'h0000_0081);
    reg_addr = 10'h21C; #1; chk("R8 request 71", reg_rdata, 32'h0000_0086);
    reg_addr = 10'h220; #1; chk("R8 request 72 absent", reg_rdata, 32'h0);
    // R9 routing
    req_in = '0; req_in[64] = 1'b1; #1;
    chk("R9 request 64 to ch1", 32'(chan_req), 32'h0000_0002);
    reg_addr = 10'h004; #1; chk("R9 pending bit", reg_rdata, 32'h0000_0108);
    req_in = '0; req_in[3] = 1'b1; #1;
    chk("R9 channel 31 routes nowhere", 32'(chan_req), 32'h0);
    step(1, 10'h100, 32'h0000_0004, '0, '0, '0, '0);
    req_in = '0; req_in[0] = 1'b1; #1;
    chk("R9 invalid entry routes nowhere", 32'(chan_req), 32'h0);
    req_in = '0; req_in[63] = 1'b1; req_in[71] = 1'b1; #1;
    chk("R9 two requests", 32'(chan_req), 32'h0000_0048);
    step(1, 10'h21C, 32'h0, '0, '0, '0, '0);
    chk("R7 zero unmaps", 32'(chan_req), 32'h0000_0008);
    req_in = '0;

    // R10 alignment
    step(1, 10'h080, 32'hFFFF_FF5A, '0, '0, '0, '0);
    reg_addr = 10'h080; #1; chk("R10 align readback", reg_rdata, 32'h0000_005A);
    chk("R10 align outputs", 32'(unaligned_ok), 32'h0000_005A);
    // R6 summary not writable, R11 holes
    step(1, 10'h084, 32'hFFFF_FFFF, '0, '0, '0, '0);
    reg_addr = 10'h084; #1; chk("R6 summary write ignored", reg_rdata, 32'h0);
    reg_addr = 10'h0A2; #1; chk("R11 unaligned addr", reg_rdata, 32'h0);
    reg_addr = 10'h300; #1; chk("R11 hole 0x300", reg_rdata, 32'h0);
    reg_addr = 10'h020; #1; chk("R11 channel beyond count", reg_rdata, 32'h0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int kind = $urandom_range(0, 9);
      int ch = $urandom_range(0, NCH - 1);
      bit [9:0] a = 10'h3FC;
      bit [31:0] d = $urandom;
      bit w = 1'b1;
      bit [9:0] ra;
      int rk;
      case (kind)
        0, 1, 2: a = 10'(ch * 4);
        3: begin a = 10'(ch * 4); d = f_chan(ch); end
        4: a = 10'h080;
        5: begin
             int r = $urandom_range(0, 79);
             a = (r < 64) ? 10'(10'h100 + 4 * r) : 10'(10'h200 + 4 * (r - 64));
           end
        6: a = 10'h084;
        default: w = 1'b0;
      endcase
      for (int r = 0; r < NREQ; r++) req_in[r] = ($urandom_range(0, 7) == 0);
      step(w, a, d, NCH'($urandom & $urandom & $urandom),
           NCH'($urandom & $urandom & $urandom),
           NCH'($urandom & $urandom & $urandom & $urandom),
           NCH'($urandom & $urandom));
      chk_outs("random");
      rk = $urandom_range(0, 4);
      case (rk)
        0: ra = 10'($urandom_range(0, 31) * 4);
        1: ra = 10'h084;
        2: ra = 10'h080;
        3: ra = 10'($urandom_range(0, 191) * 4 + 10'h100);
        default: ra = 10'($urandom);
      endcase
      chk_rd("random read R3 R4 R5 R8", ra);
      if (ra == 10'h084) chk_rd("random summary R6", 10'h084);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule